// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Interrupt

This block keeps the beam position of a raster video generator: a dot counter within each scanline and a scanline counter that starts each frame on a pre-render line (numbered -1). It runs through the visible and blanking lines and returns to the pre-render line. A region input picks between a short frame and a long frame. When the beam enters the vertical-blank line, the block raises a vertical-blank status flag and, if the interrupt is enabled, a level interrupt request. A frame-parity bit toggles once per frame. On the short-frame region it drives the one-dot shortening of odd frames while rendering is on.

A status read returns the vertical-blank flag together with two sprite status bits that arrive as inputs. The read clears the flag and the interrupt request, and it follows the race rules near the blanking start. Toggling the interrupt-enable level can re-raise the request while blanking is active, or cancel it just after blanking starts. The block emits a one-dot strobe that tells the sprite logic to clear its own hit and overflow bits.

Top module: `raster_sync`

## Requirements
- R1: `dotNum` counts 0 to DOTS_PER_LINE-1 (default 340) and then returns to 0. At that wrap `lineNum` advances by one. On the last line (SHORT_LAST_LINE=260 when `longFrame`=0, LONG_LAST_LINE=311 when 1) it returns to -1, encoded as all ones in two's complement. Reset puts the position at line -1, dot 0, with all flags low.
- R2: At the clock edge where the position enters line VBLANK_LINE (default 241) dot 0, `vblankFlag` becomes 1. At the same edge `nmiReq` becomes 1 if `nmiEnable` is high in that cycle.
- R3: While the position is line -1 dot 1, `clearSpriteFlags` is high for that one dot, and `vblankFlag` is low after the edge that ends the dot.
- R4: While `statusRead` is high, `statusData` carries the flag in bit 7, `spriteHitIn` in bit 6 and `spriteOvfIn` in bit 5, with bits 4..0 at zero. `statusData` is zero when no read is presented. A read clears `vblankFlag` and `nmiReq` at the next edge.
- R5: A read presented at line VBLANK_LINE dot 0 returns bit 7 as 0 even though the flag is set. Both the flag and the request are then clear after the edge.
- R6: A rising edge of `nmiEnable` (high now, low in the previous cycle) while `vblankFlag` is set raises `nmiReq` at the next edge. The one exception is when the position is line -1 dot 0.
- R7: A falling edge of `nmiEnable` on line VBLANK_LINE at a dot below RACE_DOTS (default 3) clears `nmiReq` at the next edge.
- R8: With `longFrame`=0, `renderOn`=1 and `oddFrame`=1, line -1 dot DOTS_PER_LINE-2 (339) is followed directly by line 0 dot 0. With `longFrame`=1 the skip never happens.
- R9: `oddFrame` toggles at the edge that ends the last dot of the last line, and holds at all other edges.
- R10: `nmiAck` clears `nmiReq` at the next edge and leaves `vblankFlag` unchanged. Entry into vertical blank with the interrupt enabled takes priority over any clear presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| longFrame | input | 1 | Region select: 0 short frame, 1 long frame |
| renderOn | input | 1 | Background or sprite rendering enabled |
| nmiEnable | input | 1 | Interrupt-enable level from the control register |
| statusRead | input | 1 | Status read strobe, one per read |
| nmiAck | input | 1 | Interrupt acknowledge, clears the request |
| spriteHitIn | input | 1 | Sprite-zero hit status from the sprite logic |
| spriteOvfIn | input | 1 | Sprite overflow status from the sprite logic |
| dotNum | output | clog2(DOTS_PER_LINE) | Current dot |
| lineNum | output | clog2(LONG_LAST_LINE+1)+1 | Current scanline, two's complement |
| oddFrame | output | 1 | Frame parity |
| vblankFlag | output | 1 | Vertical-blank status flag |
| nmiReq | output | 1 | Level interrupt request |
| statusData | output | 8 | Status byte, valid while statusRead is high |
| clearSpriteFlags | output | 1 | One-dot strobe to clear sprite hit and overflow |

## Verification
Every registered result (position, parity, flag and request) changes at the first rising edge after the cycle that presents the stimulus. The bench drives inputs just after a falling edge and advances its own model by one step per rising edge. It compares those outputs at the following falling edge. `statusData` and `clearSpriteFlags` are combinational from the current position, so they are checked in the same cycle, one time unit after the inputs settle and before the edge. The race windows, the re-enable exception, the odd-frame skip and both frame wraps are reached by steering the model to the exact dot before applying each stimulus. A long pseudo-random phase then aims reads into the race window.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;

  // Position-derived strobes passed from the counter control to the flag datapath.
  typedef struct packed {
    logic enterVblank;  // next edge enters the blanking line at dot 0
    logic preClear;     // pre-render line, dot 1
    logic raceWin;      // blanking line, dot below the race limit
    logic raceDot0;     // blanking line, dot 0
    logic preDot0;      // pre-render line, dot 0
  } rasterStrobe_t;

endpackage

// File: rtl/raster_sync_ctrl.sv
module raster_sync_ctrl
  import raster_sync_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 341,
  parameter int VBLANK_LINE     = 241,
  parameter int SHORT_LAST_LINE = 260,
  parameter int LONG_LAST_LINE  = 311,
  parameter int RACE_DOTS       = 3,
  parameter int DOT_W           = $clog2(DOTS_PER_LINE),
  parameter int LINE_W          = $clog2(LONG_LAST_LINE + 1) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              longFrame,
  input  logic              renderOn,
  output logic [DOT_W-1:0]  dotNum,
  output logic [LINE_W-1:0] lineNum,
  output logic              oddFrame,
  output rasterStrobe_t     strobe
);

  localparam logic [DOT_W-1:0]  DOT_LAST   = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  DOT_SKIP   = DOT_W'(DOTS_PER_LINE - 2);
  localparam logic [DOT_W-1:0]  DOT_RACE   = DOT_W'(RACE_DOTS);
  localparam logic [LINE_W-1:0] LINE_PRE   = '1;
  localparam logic [LINE_W-1:0] LINE_VBL   = LINE_W'(VBLANK_LINE);
  localparam logic [LINE_W-1:0] LINE_PREV  = LINE_W'(VBLANK_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_SHORT = LINE_W'(SHORT_LAST_LINE);
  localparam logic [LINE_W-1:0] LINE_LONG  = LINE_W'(LONG_LAST_LINE);

  logic [DOT_W-1:0]  dotQ;
  logic [LINE_W-1:0] lineQ;
  logic              oddQ;
  logic [LINE_W-1:0] lastLine;
  logic              atLineEnd;
  logic              atFrameEnd;
  logic              skipNow;

  always_comb begin
    lastLine   = longFrame ? LINE_LONG : LINE_SHORT;
    atLineEnd  = (dotQ == DOT_LAST);
    atFrameEnd = atLineEnd && (lineQ == lastLine);
    skipNow    = !longFrame && renderOn && oddQ && (lineQ == LINE_PRE) && (dotQ == DOT_SKIP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotQ  <= '0;
      lineQ <= LINE_PRE;
      oddQ  <= 1'b0;
    end else begin
      if (skipNow) begin
        dotQ  <= '0;
        lineQ <= '0;
      end else if (atLineEnd) begin
        dotQ  <= '0;
        lineQ <= (lineQ == lastLine) ? LINE_PRE : lineQ + 1'b1;
      end else begin
        dotQ <= dotQ + 1'b1;
      end
      if (atFrameEnd) oddQ <= !oddQ;
    end
  end

  always_comb begin
    strobe.enterVblank = atLineEnd && (lineQ == LINE_PREV);
    strobe.preClear    = (lineQ == LINE_PRE) && (dotQ == DOT_W'(1));
    strobe.raceWin     = (lineQ == LINE_VBL) && (dotQ < DOT_RACE);
    strobe.raceDot0    = (lineQ == LINE_VBL) && (dotQ == '0);
    strobe.preDot0     = (lineQ == LINE_PRE) && (dotQ == '0);
  end

  assign dotNum   = dotQ;
  assign lineNum  = lineQ;
  assign oddFrame = oddQ;

  AST_DOT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!atLineEnd && !skipNow) |=> (dotQ == $past(dotQ) + 1'b1)); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    atFrameEnd |=> (lineQ == LINE_PRE && dotQ == '0)); // R1
  AST_ODD_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    skipNow |=> (dotQ == '0 && lineQ == '0)); // R8
  AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !atFrameEnd |=> $stable(oddQ)); // R9

endmodule

// File: rtl/raster_sync_flags.sv
module raster_sync_flags
  import raster_sync_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  rasterStrobe_t strobe,
  input  logic          nmiEnable,
  input  logic          statusRead,
  input  logic          nmiAck,
  input  logic          spriteHitIn,
  input  logic          spriteOvfIn,
  output logic          vblankFlag,
  output logic          nmiReq,
  output logic [7:0]    statusData,
  output logic          clearSpriteFlags
);

  logic vblankQ;
  logic nmiQ;
  logic enPrevQ;
  logic enRise;
  logic enFall;
  logic nmiClear;
  logic nmiRetrig;

  always_comb begin
    enRise    = nmiEnable && !enPrevQ;
    enFall    = !nmiEnable && enPrevQ;
    nmiClear  = statusRead || nmiAck || (enFall && strobe.raceWin);
    nmiRetrig = enRise && vblankQ && !strobe.preDot0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vblankQ <= 1'b0;
      nmiQ    <= 1'b0;
      enPrevQ <= 1'b0;
    end else begin
      enPrevQ <= nmiEnable;
      if (strobe.enterVblank)                       vblankQ <= 1'b1;
      else if (statusRead || strobe.preClear)       vblankQ <= 1'b0;
      if (strobe.enterVblank && nmiEnable)          nmiQ <= 1'b1;
      else if (nmiClear)                            nmiQ <= 1'b0;
      else if (nmiRetrig)                           nmiQ <= 1'b1;
    end
  end

  always_comb begin
    statusData = '0;
    if (statusRead)
      statusData = {vblankQ && !strobe.raceDot0, spriteHitIn, spriteOvfIn, 5'b00000};
  end

  assign vblankFlag       = vblankQ;
  assign nmiReq           = nmiQ;
  assign clearSpriteFlags = strobe.preClear;

  AST_VBLANK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterVblank |=> vblankQ); // R2
  AST_VBLANK_NMI: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterVblank && nmiEnable) |=> nmiQ); // R2
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.preClear |=> !vblankQ); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !strobe.enterVblank) |=> (!vblankQ && !nmiQ)); // R4
  AST_REENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEnable && !enPrevQ && vblankQ && !strobe.preDot0 && !statusRead && !nmiAck) |=> nmiQ); // R6
  AST_LATE_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.raceWin && !nmiEnable && enPrevQ) |=> !nmiQ); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (nmiAck && !strobe.enterVblank) |=> !nmiQ); // R10

endmodule

// File: rtl/raster_sync.sv
module raster_sync
  import raster_sync_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 341,
  parameter int VBLANK_LINE     = 241,
  parameter int SHORT_LAST_LINE = 260,
  parameter int LONG_LAST_LINE  = 311,
  parameter int RACE_DOTS       = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   longFrame,
  input  logic                                   renderOn,
  input  logic                                   nmiEnable,
  input  logic                                   statusRead,
  input  logic                                   nmiAck,
  input  logic                                   spriteHitIn,
  input  logic                                   spriteOvfIn,
  output logic [$clog2(DOTS_PER_LINE)-1:0]       dotNum,
  output logic [$clog2(LONG_LAST_LINE + 1):0]    lineNum,
  output logic                                   oddFrame,
  output logic                                   vblankFlag,
  output logic                                   nmiReq,
  output logic [7:0]                             statusData,
  output logic                                   clearSpriteFlags
);

  localparam int DOT_W  = $clog2(DOTS_PER_LINE);
  localparam int LINE_W = $clog2(LONG_LAST_LINE + 1) + 1;

  rasterStrobe_t strobe;

  raster_sync_ctrl #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .VBLANK_LINE    (VBLANK_LINE),
    .SHORT_LAST_LINE(SHORT_LAST_LINE),
    .LONG_LAST_LINE (LONG_LAST_LINE),
    .RACE_DOTS      (RACE_DOTS),
    .DOT_W          (DOT_W),
    .LINE_W         (LINE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .longFrame(longFrame),
    .renderOn (renderOn),
    .dotNum   (dotNum),
    .lineNum  (lineNum),
    .oddFrame (oddFrame),
    .strobe   (strobe)
  );

  raster_sync_flags u_flags (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .nmiEnable       (nmiEnable),
    .statusRead      (statusRead),
    .nmiAck          (nmiAck),
    .spriteHitIn     (spriteHitIn),
    .spriteOvfIn     (spriteOvfIn),
    .vblankFlag      (vblankFlag),
    .nmiReq          (nmiReq),
    .statusData      (statusData),
    .clearSpriteFlags(clearSpriteFlags)
  );

endmodule

// File: tb/raster_sync_bench.sv
module raster_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 20;   // dots per line (scaled)
  localparam int V  = 6;    // blanking line
  localparam int SL = 9;    // short-frame last line
  localparam int LL = 13;   // long-frame last line
  localparam int RD = 3;    // race window
  localparam int DW = $clog2(D);
  localparam int LW = $clog2(LL + 1) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic longFrame = 1'b0, renderOn = 1'b0, nmiEnable = 1'b0, statusRead = 1'b0;
  logic nmiAck = 1'b0, spriteHitIn = 1'b0, spriteOvfIn = 1'b0;
  logic [DW-1:0] dotNum;
  logic [LW-1:0] lineNum;
  logic oddFrame, vblankFlag, nmiReq, clearSpriteFlags;
  logic [7:0] statusData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mDot, mLine;
  bit mVb, mNmi, mOdd, mEnPrev;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = !clk;

  raster_sync #(
    .DOTS_PER_LINE(D), .VBLANK_LINE(V), .SHORT_LAST_LINE(SL),
    .LONG_LAST_LINE(LL), .RACE_DOTS(RD)
  ) u_raster_sync (
    .clk(clk), .rstN(rstN), .longFrame(longFrame), .renderOn(renderOn),
    .nmiEnable(nmiEnable), .statusRead(statusRead), .nmiAck(nmiAck),
    .spriteHitIn(spriteHitIn), .spriteOvfIn(spriteOvfIn),
    .dotNum(dotNum), .lineNum(lineNum), .oddFrame(oddFrame),
    .vblankFlag(vblankFlag), .nmiReq(nmiReq), .statusData(statusData),
    .clearSpriteFlags(clearSpriteFlags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lineExp(input int l);
    logic [LW-1:0] v;
    v = l[LW-1:0];
    return int'(v);
  endfunction

  task automatic compareAll();
    chk("R1 dotNum", int'(dotNum), mDot);
    chk("R1 lineNum", int'(lineNum), lineExp(mLine));
    chk("R2 vblankFlag", int'(vblankFlag), int'(mVb));
    chk("nmiReq (R2 R6 R7 R10)", int'(nmiReq), int'(mNmi));
    chk("R9 oddFrame", int'(oddFrame), int'(mOdd));
  endtask

  task automatic modelAdvance();
    int lastL;
    bit enter, preClr, rise, fall, win, skip;
    lastL  = longFrame ? LL : SL;
    enter  = (mDot == D - 1) && (mLine == V - 1);
    preClr = (mLine == -1) && (mDot == 1);
    rise   = nmiEnable && !mEnPrev;
    fall   = !nmiEnable && mEnPrev;
    win    = (mLine == V) && (mDot < RD);
    skip   = !longFrame && renderOn && mOdd && (mLine == -1) && (mDot == D - 2);
    if (enter && nmiEnable) mNmi = 1;
    else if (statusRead || nmiAck || (fall && win)) mNmi = 0;
    else if (rise && mVb && !((mLine == -1) && (mDot == 0))) mNmi = 1;
    if (enter) mVb = 1;
    else if (statusRead || preClr) mVb = 0;
    if ((mDot == D - 1) && (mLine == lastL)) mOdd = !mOdd;
    mEnPrev = nmiEnable;
    if (skip) begin
      mDot = 0; mLine = 0;
    end else if (mDot == D - 1) begin
      mDot = 0;
      mLine = (mLine == lastL) ? -1 : mLine + 1;
    end else begin
      mDot = mDot + 1;
    end
  endtask

  // inputs were set just after a falling edge; check combinational outputs, then the edge
  task automatic step();
    int expSt;
    #1;
    expSt = 0;
    if (statusRead)
      expSt = ((mVb && !((mLine == V) && (mDot == 0))) ? 128 : 0)
            + (spriteHitIn ? 64 : 0) + (spriteOvfIn ? 32 : 0);
    chk("R4 statusData", int'(statusData), expSt);
    chk("R3 clearSpriteFlags", int'(clearSpriteFlags), ((mLine == -1) && (mDot == 1)) ? 1 : 0);
    modelAdvance();
    @(negedge clk);
    compareAll();
  endtask

  task automatic goTo(input int l, input int d);
    for (int g = 0; g < 20000; g++) begin
      if ((mLine == l) && (mDot == d)) break;
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual expired expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit x;
    mDot = 0; mLine = -1; mVb = 0; mNmi = 0; mOdd = 0; mEnPrev = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    chk("R1 reset dot", int'(dotNum), 0);
    chk("R1 reset line", int'(lineNum), lineExp(-1));
    chk("R2 reset vblank", int'(vblankFlag), 0);
    chk("R2 reset nmi", int'(nmiReq), 0);
    chk("R9 reset parity", int'(oddFrame), 0);

    // blanking entry and read on dot 0
    nmiEnable = 1'b1;
    goTo(V - 1, D - 1);
    step();
    chk("R2 vblank set on entry", int'(vblankFlag), 1);
    chk("R2 nmi set on entry", int'(nmiReq), 1);
    statusRead = 1'b1;
    #1 chk("R5 dot0 read bit7", int'(statusData[7]), 0);
    step();
    statusRead = 1'b0;
    chk("R5 dot0 read clears vblank", int'(vblankFlag), 0);
    chk("R5 dot0 read clears nmi", int'(nmiReq), 0);

    // late cancel, re-enable, normal read
    goTo(V - 1, D - 1);
    step();
    nmiEnable = 1'b0;
    step();
    chk("R7 cancel in race window", int'(nmiReq), 0);
    chk("R7 vblank kept", int'(vblankFlag), 1);
    goTo(V, 6);
    nmiEnable = 1'b1;
    step();
    chk("R6 re-enable raises nmi", int'(nmiReq), 1);
    spriteHitIn = 1'b1; spriteOvfIn = 1'b0; statusRead = 1'b1;
    #1 chk("R4 status byte", int'(statusData), 8'hC0);
    step();
    statusRead = 1'b0; spriteHitIn = 1'b0;
    chk("R4 read clears vblank", int'(vblankFlag), 0);
    chk("R4 read clears nmi", int'(nmiReq), 0);

    // acknowledge vs entry priority
    goTo(V - 1, D - 1);
    nmiAck = 1'b1;
    step();
    chk("R10 entry wins over ack", int'(nmiReq), 1);
    step();
    nmiAck = 1'b0;
    chk("R10 ack clears nmi", int'(nmiReq), 0);
    chk("R10 ack keeps vblank", int'(vblankFlag), 1);

    // re-enable exception at pre-render dot 0, then flag clear
    goTo(V + 1, 5);
    nmiEnable = 1'b0;
    step();
    goTo(-1, 0);
    chk("R3 vblank still set at pre-render dot 0", int'(vblankFlag), 1);
    nmiEnable = 1'b1;
    step();
    chk("R6 no retrigger at pre-render dot 0", int'(nmiReq), 0);
    #1 chk("R3 clear strobe at dot 1", int'(clearSpriteFlags), 1);
    step();
    chk("R3 vblank cleared", int'(vblankFlag), 0);

    // parity and short wrap
    goTo(SL, D - 1);
    x = mOdd;
    step();
    chk("R9 parity toggles", int'(oddFrame), int'(!x));
    chk("R1 short frame wraps", int'(lineNum), lineExp(-1));

    // odd-frame skip
    renderOn = 1'b1;
    if (!mOdd) begin
      goTo(SL, D - 1);
      step();
    end
    goTo(-1, D - 2);
    step();
    chk("R8 skip dot", int'(dotNum), 0);
    chk("R8 skip line", int'(lineNum), 0);

    // long frame: wrap and no skip
    goTo(-1, 0);
    longFrame = 1'b1;
    goTo(LL, D - 1);
    step();
    chk("R1 long frame wraps", int'(lineNum), lineExp(-1));
    chk("R9 parity odd before long pre-render", int'(oddFrame), int'(mOdd));
    goTo(-1, D - 2);
    step();
    chk("R8 no skip in long frame", int'(dotNum), D - 1);

    // pseudo-random phase against the model
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      statusRead  = (lfsr[3:0] == 4'd0) || ((mLine == V) && (mDot < RD) && lfsr[2]);
      nmiAck      = (lfsr[8:4] == 5'd0);
      if (lfsr[7:5] == 3'd0) nmiEnable = !nmiEnable;
      spriteHitIn = lfsr[9];
      spriteOvfIn = lfsr[10];
      if ((mLine == -1) && (mDot == 0) && lfsr[11]) longFrame = lfsr[12];
      renderOn    = lfsr[13] | lfsr[14];
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule